// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block sits between an 8-bit processor core and external memory or I/O. It runs each access over a shared bus that carries both the low address byte and the data. When the core presents a request, the block drives the low address byte on the shared bus and the high byte on a separate port. It marks the address phase with an active-low address strobe. It then turns the shared bus around for the data phase under an active-low data strobe. The request holds a 16-bit address, a write flag, a data-space select and the write data.

One external access is divided into bus states T1, T2, optional TW and T3. Every state lasts two ticks of the block clock. When the extended-timing input is high at acceptance, an extra two-tick state TE is placed after T2. An active-low wait input is sampled at the end of T2 (or of TE), and again at the end of each TW. Each low sample inserts one more TW. The core sees `busy` for the whole access. At the end it sees a one-tick `done` pulse, which carries the captured read data and a valid flag.

The shared bus is brought out as separate output, output-enable and input vectors, so that the pad ring can combine them.

Top module: `mux_bus_ctrl`

## Requirements
- R1: While `rstN` is low, `asN` and `dsN` are high, `adOe` is low, and `busy` and `done` are low.
- R2: An accepted request starts T1 on the next tick. `asN` is low for exactly the first tick of T1. `adOut` carries address bits 7..0 with `adOe` high during both ticks of T1. `addrHi` carries address bits 15..8 from T1 through the done tick.
- R3: `rwN` (1 = read, 0 = write) and `dmN` (low when `reqDm` is 1) take the request's values in T1. They stay unchanged through the done tick.
- R4: On a read, `adOe` is low from the first tick of T2 through the done tick. `dsN` is low from the first tick of T2 for 4 + 2·E + 2·W ticks, where E is 1 in extended mode and W is the number of wait states.
- R5: On a read, `rdData` equals the `adIn` value present on the clock edge at which `dsN` rises. `rdValid` is high during the done tick. On a write, `rdValid` stays low.
- R6: On a write, `adOut` carries the write data with `adOe` high from the first tick of T2 through the done tick, so the data is held one tick past the rise of `dsN`. `dsN` is low from the second tick of T2 for 3 + 2·E + 2·W ticks.
- R7: Each low sample of `waitN` at the end of T2 (or TE), or at the end of a TW, adds one two-tick wait state before T3.
- R8: With `extMode` high at acceptance, the access is two ticks longer. A change of `extMode` after acceptance has no effect on the access in progress.
- R9: `done` is high for exactly one tick, at tick index 6 + 2·E + 2·W counted from the first T1 tick as 0. `busy` is high from T1 through the done tick and low on the tick after.
- R10: A request presented while `busy` is high is ignored. The address, control lines and timing of the access in progress are unchanged.
- R11: After `dsN` rises, `asN` stays high for at least two ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one tick per half bus state |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present; accepted when the block is idle |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqDm | input | 1 | 1 = data-space access (drives `dmN` low) |
| reqAddr | input | 16 | Access address |
| reqWdata | input | 8 | Write data |
| extMode | input | 1 | Extended timing for the access being accepted |
| waitN | input | 1 | Active-low wait request |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-tick end-of-access pulse |
| rdData | output | 8 | Captured read data |
| rdValid | output | 1 | High with `done` on a completed read |
| adOut | output | 8 | Shared bus output value |
| adOe | output | 1 | Shared bus output enable |
| adIn | input | 8 | Shared bus input value |
| addrHi | output | 8 | High address byte |
| asN | output | 1 | Address strobe, active low |
| dsN | output | 1 | Data strobe, active low |
| rwN | output | 1 | Read (high) / write (low) |
| dmN | output | 1 | Data-space select, active low |

## Verification
The bench builds the block with its default 16-bit address and 8-bit data widths. It sweeps every combination of read or write, normal or extended timing, and zero to three wait states. This reaches every path through the bus-state sequence, including repeated TW states taken from both T2 and TE. Addresses, write data and read data change per access, and a third of the accesses keep a conflicting request asserted while busy. This exposes capture on the wrong edge, lost latching of the extended-mode flag, and acceptance of a request during an access.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_TE, S_TW, S_T3, S_DONE
  } busState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;
    logic driveAddr;
    logic driveData;
    logic capture;
    logic done;
  } busCtl_t;

endpackage

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
  import mbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    extMode,
  input  logic    waitN,
  input  logic    isWrite,
  output busCtl_t ctl,
  output logic    asN,
  output logic    dsN,
  output logic    busy
);

  busState_t state, stateNext;
  logic      phase, phaseNext;
  logic      extR;

  // State after the second tick of T2/TE/TW: wait sampling point
  function automatic busState_t afterSample(input logic w);
    return w ? S_T3 : S_TW;
  endfunction

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    unique case (state)
      S_IDLE: begin
        phaseNext = 1'b0;
        if (reqValid) stateNext = S_T1;
      end
      S_DONE: begin
        stateNext = S_IDLE;
        phaseNext = 1'b0;
      end
      default: begin
        if (!phase) begin
          phaseNext = 1'b1;
        end else begin
          phaseNext = 1'b0;
          case (state)
            S_T1:    stateNext = S_T2;
            S_T2:    stateNext = extR ? S_TE : afterSample(waitN);
            S_TE:    stateNext = afterSample(waitN);
            S_TW:    stateNext = afterSample(waitN);
            S_T3:    stateNext = S_DONE;
            default: stateNext = S_IDLE;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= 1'b0;
      extR  <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      if (state == S_IDLE && reqValid) extR <= extMode;
    end
  end

  logic dataPhase;
  assign dataPhase = (state == S_T2) || (state == S_TE) ||
                     (state == S_TW) || (state == S_T3);

  assign asN  = !(state == S_T1 && !phase);
  // Reads strobe from the start of T2, writes from its second tick
  assign dsN  = !(dataPhase && !(isWrite && state == S_T2 && !phase));
  assign busy = (state != S_IDLE);

  assign ctl.load      = (state == S_IDLE) && reqValid;
  assign ctl.driveAddr = (state == S_T1);
  assign ctl.driveData = isWrite && (dataPhase || state == S_DONE);
  assign ctl.capture   = !isWrite && (state == S_T3) && phase;
  assign ctl.done      = (state == S_DONE);

endmodule

// File: rtl/mbus_dp.sv
module mbus_dp
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busCtl_t              ctl,
  input  logic                 reqWrite,
  input  logic                 reqDm,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqWdata,
  input  logic [DATA_W-1:0]    adIn,
  output logic [DATA_W-1:0]    adOut,
  output logic                 adOe,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                 rwN,
  output logic                 dmN,
  output logic                 isWrite,
  output logic [DATA_W-1:0]    rdData,
  output logic                 rdValid
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrR;
  logic [DATA_W-1:0] wdataR;
  logic [DATA_W-1:0] rdR;
  logic              rwNR, dmNR, rdOkR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR  <= '0;
      wdataR <= '0;
      rdR    <= '0;
      rwNR   <= 1'b1;
      dmNR   <= 1'b1;
      rdOkR  <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrR  <= reqAddr;
        wdataR <= reqWdata;
        rwNR   <= !reqWrite;
        dmNR   <= !reqDm;
        rdOkR  <= 1'b0;
      end
      if (ctl.capture) begin
        rdR   <= adIn;
        rdOkR <= 1'b1;
      end
    end
  end

  assign adOut   = ctl.driveAddr ? addrR[DATA_W-1:0] : wdataR;
  assign adOe    = ctl.driveAddr || ctl.driveData;
  assign addrHi  = addrR[ADDR_W-1 -: HI_W];
  assign rwN     = rwNR;
  assign dmN     = dmNR;
  assign isWrite = !rwNR;
  assign rdData  = rdR;
  assign rdValid = ctl.done && rdOkR;

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqDm,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     extMode,
  input  logic                     waitN,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  input  logic [DATA_W-1:0]        adIn,
  output logic [ADDR_W-DATA_W-1:0] addrHi,
  output logic                     asN,
  output logic                     dsN,
  output logic                     rwN,
  output logic                     dmN
);

  busCtl_t ctl;
  logic    isWrite;

  mbus_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .extMode(extMode),
    .waitN(waitN), .isWrite(isWrite), .ctl(ctl),
    .asN(asN), .dsN(dsN), .busy(busy)
  );

  mbus_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqDm(reqDm),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .adIn(adIn), .adOut(adOut),
    .adOe(adOe), .addrHi(addrHi), .rwN(rwN), .dmN(dmN), .isWrite(isWrite),
    .rdData(rdData), .rdValid(rdValid)
  );

  assign done = ctl.done;

endmodule

// File: rtl/mbus_checker.sv
module mbus_checker (
  input logic clk,
  input logic rstN,
  input logic asN,
  input logic dsN,
  input logic rwN,
  input logic dmN,
  input logic adOe,
  input logic done,
  input logic busy
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |-> (asN && dsN && !adOe && !busy && !done));

  p_as_one_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    !asN |=> asN);

  p_as_ds_apart_r2: assert property (@(posedge clk) disable iff (!rstN)
    !asN |-> dsN);

  p_ctl_stable_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dsN |-> ($stable(rwN) && $stable(dmN)));

  p_read_float_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && rwN) |-> !adOe);

  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dsN && !rwN) |-> adOe);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  p_as_gap_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dsN) |-> asN ##1 asN);

endmodule

bind mux_bus_ctrl mbus_checker u_chk (
  .clk(clk), .rstN(rstN), .asN(asN), .dsN(dsN), .rwN(rwN), .dmN(dmN),
  .adOe(adOe), .done(done), .busy(busy)
);

// File: tb/tb_mux_bus_ctrl.sv
`timescale 1ns/1ps
module tb_mux_bus_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqDm = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        extMode = 1'b0, waitN = 1'b1;
  logic        busy, done, rdValid, adOe, asN, dsN, rwN, dmN;
  logic [7:0]  rdData, adOut, adIn = '0, addrHi;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_bus_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqDm(reqDm), .reqAddr(reqAddr), .reqWdata(reqWdata), .extMode(extMode),
    .waitN(waitN), .busy(busy), .done(done), .rdData(rdData),
    .rdValid(rdValid), .adOut(adOut), .adOe(adOe), .adIn(adIn),
    .addrHi(addrHi), .asN(asN), .dsN(dsN), .rwN(rwN), .dmN(dmN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic runTxn(input bit wr, input bit dm, input logic [15:0] a,
                        input logic [7:0] wd, input bit ext, input int w,
                        input logic [7:0] rv, input bit junk);
    int L = 6 + 2 * int'(ext) + 2 * w;
    int asLow = 0, asFirst = -1, dsLow = 0, dsFirst = -1;
    int doneCnt = 0, doneIdx = -1;
    bit okAddr = 1, okCtl = 1, okBus = 1, okBusy = 1, okRd = 1, okGap = 1;
    int dsExpFirst = wr ? 3 : 2;
    int dsExpLen = (wr ? 3 : 4) + 2 * int'(ext) + 2 * w;
    string tTag;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqDm = dm; reqAddr = a;
    reqWdata = wd; extMode = ext;
    for (int idx = 0; idx <= L + 1; idx++) begin
      @(negedge clk);
      if (!asN) begin asLow++; if (asFirst < 0) asFirst = idx; end
      if (!dsN) begin dsLow++; if (dsFirst < 0) dsFirst = idx; end
      if (idx <= 1) okAddr &= adOe && (adOut == a[7:0]);
      if (idx <= L) begin
        okAddr &= (addrHi == a[15:8]);
        okCtl  &= (rwN == !wr) && (dmN == !dm);
        okBusy &= busy;
      end
      if (idx >= 2 && idx <= L)
        okBus &= wr ? (adOe && adOut == wd) : !adOe;
      if (done) begin
        doneCnt++; doneIdx = idx;
        okRd &= (rdValid == !wr) && (wr || rdData == rv);
      end
      if (idx >= L) okGap &= asN;
      if (idx == L + 1) okBusy &= !busy && !adOe;
      if (idx == 0) begin
        if (junk) begin
          reqAddr = ~a; reqWrite = !wr; reqDm = !dm; extMode = !ext;
          reqWdata = ~wd;
        end else reqValid = 0;
      end
      if (idx == L) reqValid = 0;
      waitN = !(idx >= 3 + 2 * int'(ext) && idx < 3 + 2 * int'(ext) + 2 * w);
      adIn = (idx == L - 1) ? rv : ~rv;
    end
    waitN = 1;
    chk(asLow == 1 && asFirst == 0 && okAddr, "R2", "address phase asLow/ok",
        asLow * 10 + int'(okAddr), 11);
    chk(okCtl, "R3", "rwN/dmN held", int'(okCtl), 1);
    if (wr) begin
      chk(dsFirst == dsExpFirst && dsLow == dsExpLen, "R6", "write dsN length",
          dsLow, dsExpLen);
      chk(okBus, "R6", "write data drive", int'(okBus), 1);
    end else begin
      chk(dsFirst == dsExpFirst && dsLow == dsExpLen, "R4", "read dsN length",
          dsLow, dsExpLen);
      chk(okBus, "R4", "read bus released", int'(okBus), 1);
    end
    chk(okRd, "R5", "read capture/valid", int'(rdData), int'(rv));
    tTag = (w > 0) ? "R7" : (ext ? "R8" : "R9");
    chk(doneCnt == 1 && doneIdx == L, tTag, "done tick index", doneIdx, L);
    chk(okBusy, "R9", "busy window", int'(okBusy), 1);
    chk(okGap, "R11", "asN high after dsN rise", int'(okGap), 1);
    if (junk)
      chk(okAddr && okCtl && doneIdx == L, "R10", "request while busy ignored",
          doneIdx, L);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(asN && dsN && !adOe && !busy && !done, "R1", "reset outputs",
        {asN, dsN, adOe, busy, done}, 5'b11000);
    rstN = 1;
    @(negedge clk);
    chk(!busy && asN && dsN, "R1", "idle after reset", int'(busy), 0);
    begin
      int k = 0;
      for (int wr = 0; wr < 2; wr++)
        for (int ext = 0; ext < 2; ext++)
          for (int w = 0; w < 4; w++)
            for (int rep = 0; rep < 2; rep++) begin
              logic [15:0] a = 16'h1234 ^ 16'(k * 16'h0F1D + rep * 16'h8001);
              logic [7:0]  wd = 8'(8'h5A + k * 8'h13);
              logic [7:0]  rv = 8'(8'hC3 ^ (k * 8'h27));
              runTxn(wr[0], k[0], a, wd, ext[0], w, rv, (k % 3) == 0);
              k++;
            end
    end
    finished = 1;
    report();
  end

endmodule